// File: doc/BRIEF.md
# Four-Slot Header Record Handoff Buffer

This block sits between a header extractor and a lookup engine. It keeps four record slots; each slot holds thirty-two 16-bit header words and a 4-bit packet identifier. A single full/free bit per slot decides who owns it. The writer side claims a free slot, fills it word by word in any order, and then commits it. The reader side claims a full slot, reads any word of it by address, and releases it when done.

Both sides are small state machines. The writer machine has the states W_IDLE and W_FILL. It moves from W_IDLE to W_FILL on a claim while a free slot exists, and from W_FILL back to W_IDLE on commit. The reader machine has the states R_IDLE and R_HOLD. It moves from R_IDLE to R_HOLD on a claim while a full slot exists, and from R_HOLD back to R_IDLE on release. The two machines and the two memory ports run fully independently of each other, cycle by cycle.

Top module: `hdr_slot_buf`

## Requirements
- R1: After reset all four status bits are 0, both sides are idle (`wr_busy`=0, `rd_busy`=0), `wr_avail`=1 and `rd_avail`=0.
- R2: `wr_start` while the writer is idle and some status bit is 0 makes `wr_busy`=1 on the next cycle, with `wr_slot` equal to the lowest-numbered slot whose bit is 0.
- R3: Word writes never change `slot_full`. `wr_commit` while `wr_busy` sets bit `wr_slot` and clears `wr_busy` on the next cycle, and stores `wr_pid` with the record. No status bit rises without a commit.
- R4: `rd_start` while the reader is idle and some bit is 1 makes `rd_busy`=1 on the next cycle. `rd_slot` is the first full slot found when searching upward (wrapping from 3 to 0) from one past the slot last claimed. Before any claim, the search starts at slot 0.
- R5: While `rd_busy`=1, `rd_data` one cycle after `rd_addr` is presented equals the word last written at that address of slot `rd_slot`, and `rd_pid` equals the identifier committed with that slot.
- R6: `rd_release` while `rd_busy` clears bit `rd_slot` and clears `rd_busy` on the next cycle. No status bit falls without a release.
- R7: A claim, a word write or read, and a commit or release on both sides in the same cycle all take effect. The writer and the reader never hold the same slot.
- R8: The following have no effect: `wr_en` and `wr_commit` while the writer is idle; `rd_release` while the reader is idle; `wr_start` when all bits are 1; `rd_start` when all bits are 0.
- R9: `wr_avail` is 1 exactly when the writer is idle and some bit is 0. `rd_avail` is 1 exactly when the reader is idle and some bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_start | input | 1 | Writer claims the lowest free slot |
| wr_en | input | 1 | Write one word into the held slot |
| wr_addr | input | 5 | Word index for the write |
| wr_data | input | 16 | Word value |
| wr_commit | input | 1 | Mark the held slot full |
| wr_pid | input | 4 | Packet identifier stored on commit |
| wr_avail | output | 1 | Writer idle and a free slot exists |
| wr_busy | output | 1 | Writer holds a slot |
| wr_slot | output | 2 | Slot held by the writer |
| rd_start | input | 1 | Reader claims the next full slot in rotation |
| rd_addr | input | 5 | Word index for the read |
| rd_release | input | 1 | Free the held slot |
| rd_avail | output | 1 | Reader idle and a full slot exists |
| rd_busy | output | 1 | Reader holds a slot |
| rd_slot | output | 2 | Slot held by the reader |
| rd_data | output | 16 | Registered read word |
| rd_pid | output | 4 | Identifier of the held record |
| slot_full | output | 4 | Status bits, one per slot |

## Verification
Claims, commits and releases show on `wr_busy`, `wr_slot`, `rd_busy`, `rd_slot` and `slot_full` one clock edge after the request is sampled. `rd_data` follows `rd_addr` after exactly one edge. `rd_pid` is valid as soon as the claim is visible. The bench changes inputs on the falling edge and compares outputs at the next falling edge, after exactly one rising edge, against a model of slot contents, status bits and rotation pointer. A fixed-seed random mix of fills, drains and overlapped fill/drain runs alongside directed cases for the ignored requests.

// File: rtl/hdr_slot_pkg.sv
package hdr_slot_pkg;
    typedef enum logic {W_IDLE, W_FILL} wr_state_e;
    typedef enum logic {R_IDLE, R_HOLD} rd_state_e;
endpackage

// File: rtl/hslot_wr_fsm.sv
module hslot_wr_fsm
    import hdr_slot_pkg::*;
#(
    parameter int N  = 4,
    parameter int SW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          commit,
    input  logic [N-1:0]  full,
    output logic          busy,
    output logic          free_any,
    output logic [SW-1:0] slot,
    output logic [N-1:0]  set_vec
);
    wr_state_e     state_q, state_n;
    logic [SW-1:0] slot_q;
    logic [SW-1:0] free_idx;

    // lowest-numbered free slot wins
    always_comb begin
        free_any = 1'b0;
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!full[i]) begin
                free_any = 1'b1;
                free_idx = SW'(i);
            end
        end
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            W_IDLE: if (start && free_any) state_n = W_FILL;
            W_FILL: if (commit)            state_n = W_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= W_IDLE;
            slot_q  <= '0;
        end else begin
            state_q <= state_n;
            if (state_q == W_IDLE && start && free_any) slot_q <= free_idx;
        end
    end

    always_comb begin
        busy    = (state_q == W_FILL);
        slot    = slot_q;
        set_vec = (busy && commit) ? (N'(1) << slot_q) : '0;
    end

    // R2
    wr_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == W_IDLE && start && free_any) |=> (busy && !full[slot_q]));
endmodule

// File: rtl/hslot_rd_fsm.sv
module hslot_rd_fsm
    import hdr_slot_pkg::*;
#(
    parameter int N  = 4,
    parameter int SW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          release_i,
    input  logic [N-1:0]  full,
    output logic          busy,
    output logic          full_any,
    output logic [SW-1:0] slot,
    output logic [N-1:0]  clr_vec
);
    rd_state_e     state_q, state_n;
    logic [SW-1:0] slot_q;
    logic [SW-1:0] last_q;
    logic [SW-1:0] pick;

    // rotate: nearest full slot after the one last claimed
    always_comb begin
        full_any = 1'b0;
        pick     = '0;
        for (int k = N; k >= 1; k--) begin
            if (full[(int'(last_q) + k) % N]) begin
                full_any = 1'b1;
                pick     = SW'((int'(last_q) + k) % N);
            end
        end
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            R_IDLE: if (start && full_any) state_n = R_HOLD;
            R_HOLD: if (release_i)         state_n = R_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= R_IDLE;
            slot_q  <= '0;
            last_q  <= SW'(N - 1);
        end else begin
            state_q <= state_n;
            if (state_q == R_IDLE && start && full_any) begin
                slot_q <= pick;
                last_q <= pick;
            end
        end
    end

    always_comb begin
        busy    = (state_q == R_HOLD);
        slot    = slot_q;
        clr_vec = (busy && release_i) ? (N'(1) << slot_q) : '0;
    end

    // R4
    rd_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == R_IDLE && start && full_any) |=> (busy && full[slot_q]));
endmodule

// File: rtl/hslot_store.sv
module hslot_store #(
    parameter int N     = 4,
    parameter int NR    = 32,
    parameter int REG_W = 16,
    parameter int PID_W = 4,
    parameter int SW    = $clog2(N),
    parameter int AW    = $clog2(NR)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [SW-1:0]    w_slot,
    input  logic [AW-1:0]    w_addr,
    input  logic [REG_W-1:0] w_data,
    input  logic             pid_we,
    input  logic [PID_W-1:0] w_pid,
    input  logic [SW-1:0]    r_slot,
    input  logic [AW-1:0]    r_addr,
    output logic [REG_W-1:0] r_data,
    output logic [PID_W-1:0] r_pid
);
    localparam int DEPTH = N * NR;

    logic [REG_W-1:0] mem [DEPTH];
    logic [PID_W-1:0] pid_q [N];
    logic [REG_W-1:0] r_data_q;

    always_ff @(posedge clk) begin
        if (we) mem[{w_slot, w_addr}] <= w_data;
        r_data_q <= mem[{r_slot, r_addr}];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) pid_q[i] <= '0;
        end else if (pid_we) begin
            pid_q[w_slot] <= w_pid;
        end
    end

    assign r_data = r_data_q;
    assign r_pid  = pid_q[r_slot];
endmodule

// File: rtl/hdr_slot_buf.sv
module hdr_slot_buf #(
    parameter int N     = 4,
    parameter int NR    = 32,
    parameter int REG_W = 16,
    parameter int PID_W = 4,
    localparam int SW   = $clog2(N),
    localparam int AW   = $clog2(NR)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_start,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic             wr_commit,
    input  logic [PID_W-1:0] wr_pid,
    output logic             wr_avail,
    output logic             wr_busy,
    output logic [SW-1:0]    wr_slot,
    input  logic             rd_start,
    input  logic [AW-1:0]    rd_addr,
    input  logic             rd_release,
    output logic             rd_avail,
    output logic             rd_busy,
    output logic [SW-1:0]    rd_slot,
    output logic [REG_W-1:0] rd_data,
    output logic [PID_W-1:0] rd_pid,
    output logic [N-1:0]     slot_full
);
    logic [N-1:0] full_q;
    logic [N-1:0] set_vec, clr_vec;
    logic         free_any, full_any;

    hslot_wr_fsm #(.N(N)) u_wr (
        .clk(clk), .rst_n(rst_n), .start(wr_start), .commit(wr_commit),
        .full(full_q), .busy(wr_busy), .free_any(free_any),
        .slot(wr_slot), .set_vec(set_vec)
    );

    hslot_rd_fsm #(.N(N)) u_rd (
        .clk(clk), .rst_n(rst_n), .start(rd_start), .release_i(rd_release),
        .full(full_q), .busy(rd_busy), .full_any(full_any),
        .slot(rd_slot), .clr_vec(clr_vec)
    );

    hslot_store #(.N(N), .NR(NR), .REG_W(REG_W), .PID_W(PID_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .we(wr_busy && wr_en), .w_slot(wr_slot), .w_addr(wr_addr),
        .w_data(wr_data), .pid_we(wr_busy && wr_commit), .w_pid(wr_pid),
        .r_slot(rd_slot), .r_addr(rd_addr), .r_data(rd_data), .r_pid(rd_pid)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) full_q <= '0;
        else        full_q <= (full_q | set_vec) & ~clr_vec;
    end

    assign slot_full = full_q;
    assign wr_avail  = !wr_busy && free_any;
    assign rd_avail  = !rd_busy && full_any;

    // R3
    rise_needs_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_busy && wr_commit) |=> ((slot_full & ~$past(slot_full)) == '0));

    // R6
    fall_needs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_busy && rd_release) |=> ((~slot_full & $past(slot_full)) == '0));

    // R7
    no_shared_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_busy && rd_busy && wr_slot == rd_slot));

    // R2
    writer_slot_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_busy |-> !slot_full[wr_slot]);

    // R4
    reader_slot_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_busy |-> slot_full[rd_slot]);
endmodule

// File: tb/hdr_slot_buf_tb.sv
module hdr_slot_buf_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_start, wr_en, wr_commit;
    logic [4:0]  wr_addr;
    logic [15:0] wr_data;
    logic [3:0]  wr_pid;
    logic        wr_avail, wr_busy;
    logic [1:0]  wr_slot;
    logic        rd_start, rd_release;
    logic [4:0]  rd_addr;
    logic        rd_avail, rd_busy;
    logic [1:0]  rd_slot;
    logic [15:0] rd_data;
    logic [3:0]  rd_pid;
    logic [3:0]  slot_full;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [15:0] mmem [4][32];
    logic [3:0]  mpid [4];
    logic [3:0]  mfull;
    int          mlast;

    always #4 clk = ~clk;

    hdr_slot_buf u_dut (
        .clk(clk), .rst_n(rst_n),
        .wr_start(wr_start), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_commit(wr_commit), .wr_pid(wr_pid), .wr_avail(wr_avail),
        .wr_busy(wr_busy), .wr_slot(wr_slot),
        .rd_start(rd_start), .rd_addr(rd_addr), .rd_release(rd_release),
        .rd_avail(rd_avail), .rd_busy(rd_busy), .rd_slot(rd_slot),
        .rd_data(rd_data), .rd_pid(rd_pid), .slot_full(slot_full)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int exp_free();
        for (int i = 0; i < 4; i++) if (!mfull[i]) return i;
        return -1;
    endfunction

    function automatic int exp_rr();
        for (int k = 1; k <= 4; k++) if (mfull[(mlast + k) % 4]) return (mlast + k) % 4;
        return -1;
    endfunction

    task automatic write_record(input logic [3:0] pid);
        int s;
        s = exp_free();
        chk(wr_avail == 1'b1, "R9 wr_avail", wr_avail, 1);
        wr_start = 1; step(); wr_start = 0;
        chk(wr_busy == 1'b1, "R2 busy", wr_busy, 1);
        chk(int'(wr_slot) == s, "R2 slot", wr_slot, s);
        for (int a = 0; a < 32; a++) begin
            wr_en = 1; wr_addr = 5'(a); wr_data = 16'($urandom);
            mmem[s][a] = wr_data;
            step();
        end
        wr_en = 0;
        chk(slot_full == mfull, "R3 no early set", slot_full, mfull);
        wr_commit = 1; wr_pid = pid; step(); wr_commit = 0;
        mfull[s] = 1'b1; mpid[s] = pid;
        chk(slot_full == mfull, "R3 set", slot_full, mfull);
        chk(wr_busy == 1'b0, "R3 idle", wr_busy, 0);
    endtask

    task automatic read_record();
        int s;
        s = exp_rr();
        chk(rd_avail == 1'b1, "R9 rd_avail", rd_avail, 1);
        rd_start = 1; step(); rd_start = 0;
        mlast = s;
        chk(rd_busy == 1'b1, "R4 busy", rd_busy, 1);
        chk(int'(rd_slot) == s, "R4 slot", rd_slot, s);
        chk(rd_pid == mpid[s], "R5 pid", rd_pid, mpid[s]);
        chk(rd_avail == 1'b0, "R9 rd_avail busy", rd_avail, 0);
        for (int i = 0; i < 40; i++) begin
            int a;
            a = (i < 32) ? i : int'($urandom % 32);
            rd_addr = 5'(a); step();
            chk(rd_data == mmem[s][a], "R5 data", rd_data, mmem[s][a]);
        end
        rd_release = 1; step(); rd_release = 0;
        mfull[s] = 1'b0;
        chk(slot_full == mfull, "R6 clear", slot_full, mfull);
        chk(rd_busy == 1'b0, "R6 idle", rd_busy, 0);
    endtask

    task automatic overlap_record(input logic [3:0] pid);
        int ws, rs;
        ws = exp_free(); rs = exp_rr();
        wr_start = 1; rd_start = 1; step(); wr_start = 0; rd_start = 0;
        mlast = rs;
        chk(int'(wr_slot) == ws && wr_busy, "R7 wr claim", wr_slot, ws);
        chk(int'(rd_slot) == rs && rd_busy, "R7 rd claim", rd_slot, rs);
        for (int a = 0; a < 32; a++) begin
            int b;
            b = int'($urandom % 32);
            wr_en = 1; wr_addr = 5'(a); wr_data = 16'($urandom);
            mmem[ws][a] = wr_data;
            rd_addr = 5'(b);
            step();
            chk(rd_data == mmem[rs][b], "R7 read during write", rd_data, mmem[rs][b]);
        end
        wr_en = 0;
        wr_commit = 1; wr_pid = pid; rd_release = 1; step();
        wr_commit = 0; rd_release = 0;
        mfull[ws] = 1'b1; mfull[rs] = 1'b0; mpid[ws] = pid;
        chk(slot_full == mfull, "R7 commit+release", slot_full, mfull);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20031));
        rst_n = 0; wr_start = 0; wr_en = 0; wr_commit = 0; wr_addr = 0;
        wr_data = 0; wr_pid = 0; rd_start = 0; rd_release = 0; rd_addr = 0;
        mfull = 0; mlast = 3;
        for (int i = 0; i < 4; i++) mpid[i] = 0;
        repeat (3) step();
        rst_n = 1;
        step();
        // R1 reset state
        chk(slot_full == 4'h0, "R1 status", slot_full, 0);
        chk(wr_busy == 0 && rd_busy == 0, "R1 idle", {wr_busy, rd_busy}, 0);
        chk(wr_avail == 1 && rd_avail == 0, "R1 flags", {wr_avail, rd_avail}, 2);

        // R8 idle requests ignored on empty buffer
        rd_start = 1; step(); rd_start = 0;
        chk(rd_busy == 0, "R8 rd_start empty", rd_busy, 0);
        rd_release = 1; step(); rd_release = 0;
        chk(slot_full == 4'h0, "R8 rd_release idle", slot_full, 0);
        wr_en = 1; wr_commit = 1; step(); wr_en = 0; wr_commit = 0;
        chk(slot_full == 4'h0 && wr_busy == 0, "R8 commit idle", slot_full, 0);

        for (int p = 0; p < 4; p++) write_record(4'(p + 4));
        chk(wr_avail == 0, "R9 wr_avail full", wr_avail, 0);
        wr_start = 1; step(); wr_start = 0;
        chk(wr_busy == 0, "R8 wr_start all full", wr_busy, 0);
        wr_en = 1; wr_addr = 5'd5; wr_data = 16'hffff; wr_commit = 1; step();
        wr_en = 0; wr_commit = 0;
        chk(slot_full == 4'hf, "R8 idle write", slot_full, 15);

        read_record();
        write_record(4'd9);
        read_record();
        overlap_record(4'd3);

        for (int it = 0; it < 80; it++) begin
            int r;
            r = int'($urandom % 3);
            if (r == 2 && mfull != 4'h0 && mfull != 4'hf) overlap_record(4'($urandom));
            else if (r == 1 && mfull != 4'h0) read_record();
            else if (mfull != 4'hf) write_record(4'($urandom));
            else read_record();
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule